// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port Controller

This block is a 32-pin general-purpose I/O port with a word-wide register port. Software sets an output value and a direction for every pin. Pin inputs pass through a two-flop synchroniser into a pad-level word. Every input pin can raise a sticky event bit when it meets a chosen condition. The condition is a high level, a low level, a rising edge or a falling edge, or any change at all when that pin's any-edge override is set. Event bits are cleared by writing ones. The masked events drive one interrupt line, or two lines when the split option assigns the lower and upper pin halves to separate outputs.

The register port is one cycle wide. A write commits on the clock edge where `busSel` and `busWr` are both high. Read data is combinational from the addressed register while `busSel` is high and `busWr` is low. Only aligned word offsets decode. The any-edge word exists only when `HAS_ANYEDGE` is set, and `SPLIT_IRQ` selects the interrupt split.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads zero, `padOe`, `padOut` and `irqOut` are zero, and all pins are inputs in mode 00 (low level) with all interrupts masked.
- R2: Word 0x00 drives `padOut`. Word 0x04 (the direction word, 1 = output) drives `padOe`. Both read back what was written.
- R3: A `padIn` change appears in the pad word (0x08) after two rising edges. The pad word reads zero on output pins. A read of word 0x00 returns the written data bit on output pins and the pad-word bit on input pins.
- R4: Pin n's 2-bit mode sits at bits 2n+1:2n of word 0x0C for pins 0–15, and of word 0x10 for pin n, taking bits 2(n-16)+1:2(n-16) for pins 16–31.
- R5: Mode 00 sets the pin's event bit in word 0x18 on every cycle the synchronised level is 0. Mode 01 does the same while the level is 1.
- R6: Mode 10 sets the event bit on a synchronised 0-to-1 change, and mode 11 sets it on a 1-to-0 change.
- R7: When bit n of the any-edge word (0x1C) is 1, pin n's event bit is set on every synchronised change, whatever its mode.
- R8: A pin whose direction bit is 1 never sets its event bit.
- R9: Writing word 0x18 clears each event bit written as 1 and leaves the other bits unchanged. A detection in the same cycle as the clear keeps the bit set, so a level that is still present re-sets its bit at once.
- R10: With `SPLIT_IRQ`=0, `irqOut[0]` is the OR over all pins of event AND mask (word 0x14), and `irqOut[1]` is 0. With `SPLIT_IRQ`=1, `irqOut[0]` covers pins 15:0 and `irqOut[1]` covers pins 31:16.
- R11: Misaligned offsets (low two address bits not zero) read zero and ignore writes. Writes to the pad word have no effect. With `HAS_ANYEDGE`=0, the any-edge word reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the addressed word |
| busWdata | input | NPINS | Write data |
| busRdata | output | NPINS | Read data, zero when not reading a mapped word |
| padIn | input | NPINS | Asynchronous pin input levels |
| padOut | output | NPINS | Pin output values |
| padOe | output | NPINS | Pin output enables (direction word) |
| irqOut | output | 2 | Interrupt requests |

## Verification
The checker assumes that a write strobe is held for exactly one clock and that `padIn` is the only asynchronous input. It also assumes that event bits can disappear only through a write of ones to the event word, so the stickiness property treats any other loss of a bit as an error. The stimulus changes `padIn` only at falling clock edges and holds each new pattern for several cycles, so that every change passes through the synchroniser as a single clean transition. The stimulus also rewrites the mode words only while the pads are steady, and then clears the event word. As a result, no edge-mode transient is left behind from a half-written configuration.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_COUNT = 8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PAD,
    SEL_MODELO,
    SEL_MODEHI,
    SEL_MASK,
    SEL_EVENT,
    SEL_ANY
  } rdSel_e;

  typedef struct packed {
    logic data;
    logic dir;
    logic modeLo;
    logic modeHi;
    logic mask;
    logic evClr;
    logic any;
  } wrStrb_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter bit HAS_ANYEDGE = 1'b1
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrb_t           strb,
  output rdSel_e            rdSel
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  rdSel_e           decSel;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    decSel = SEL_NONE;
    case (int'(wordIdx))
      0: decSel = SEL_DATA;
      1: decSel = SEL_DIR;
      2: decSel = SEL_PAD;
      3: decSel = SEL_MODELO;
      4: decSel = SEL_MODEHI;
      5: decSel = SEL_MASK;
      6: decSel = SEL_EVENT;
      7: decSel = HAS_ANYEDGE ? SEL_ANY : SEL_NONE;
      default: decSel = SEL_NONE;
    endcase
    if (!aligned) decSel = SEL_NONE;
  end

  assign rdSel = (busSel && !busWr) ? decSel : SEL_NONE;

  always_comb begin
    strb = '0;
    if (busSel && busWr) begin
      case (decSel)
        SEL_DATA:   strb.data   = 1'b1;
        SEL_DIR:    strb.dir    = 1'b1;
        SEL_MODELO: strb.modeLo = 1'b1;
        SEL_MODEHI: strb.modeHi = 1'b1;
        SEL_MASK:   strb.mask   = 1'b1;
        SEL_EVENT:  strb.evClr  = 1'b1;
        SEL_ANY:    strb.any    = 1'b1;
        default:    strb        = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter bit HAS_ANYEDGE = 1'b1,
  parameter bit SPLIT_IRQ   = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrb_t          strb,
  input  rdSel_e           rdSel,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] padIn,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] padOut,
  output logic [NPINS-1:0] padOe,
  output logic [1:0]       irqOut,
  output logic [NPINS-1:0] statVec,
  output logic [NPINS-1:0] maskVec
);

  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0]   dataQ, dirQ, maskQ, evQ, anyQ;
  logic [2*NPINS-1:0] modeQ;
  logic [NPINS-1:0]   syncA, syncQ, prevQ;
  logic [NPINS-1:0]   hitVec, clrVec, pendVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      maskQ <= '0;
      modeQ <= '0;
      syncA <= '0;
      syncQ <= '0;
      prevQ <= '0;
      evQ   <= '0;
    end else begin
      syncA <= padIn;
      syncQ <= syncA;
      prevQ <= syncQ;
      if (strb.data)   dataQ <= wdata;
      if (strb.dir)    dirQ  <= wdata;
      if (strb.mask)   maskQ <= wdata;
      if (strb.modeLo) modeQ[NPINS-1:0]       <= wdata;
      if (strb.modeHi) modeQ[2*NPINS-1:NPINS] <= wdata;
      evQ <= (evQ & ~clrVec) | hitVec;
    end
  end

  generate
    if (HAS_ANYEDGE) begin : g_any
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        anyQ <= '0;
        else if (strb.any) anyQ <= wdata;
      end
    end else begin : g_noAny
      assign anyQ = '0;
    end
  endgenerate

  assign clrVec = strb.evClr ? wdata : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] mode;
    logic       changed;
    logic       modeHit;
    assign mode    = modeQ[2*i +: 2];
    assign changed = syncQ[i] ^ prevQ[i];
    assign modeHit = mode[1] ? (changed && (syncQ[i] != mode[0]))
                             : (syncQ[i] == mode[0]);
    assign hitVec[i] = !dirQ[i] && (anyQ[i] ? changed : modeHit);
  end

  assign pendVec = evQ & maskQ;

  generate
    if (SPLIT_IRQ) begin : g_split
      assign irqOut = {|pendVec[NPINS-1:HALF], |pendVec[HALF-1:0]};
    end else begin : g_single
      assign irqOut = {1'b0, |pendVec};
    end
  endgenerate

  always_comb begin
    case (rdSel)
      SEL_DATA:   rdata = (dataQ & dirQ) | (syncQ & ~dirQ);
      SEL_DIR:    rdata = dirQ;
      SEL_PAD:    rdata = syncQ & ~dirQ;
      SEL_MODELO: rdata = modeQ[NPINS-1:0];
      SEL_MODEHI: rdata = modeQ[2*NPINS-1:NPINS];
      SEL_MASK:   rdata = maskQ;
      SEL_EVENT:  rdata = evQ;
      SEL_ANY:    rdata = anyQ;
      default:    rdata = '0;
    endcase
  end

  assign padOut  = dataQ;
  assign padOe   = dirQ;
  assign statVec = evQ;
  assign maskVec = maskQ;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 5,
  parameter bit HAS_ANYEDGE = 1'b1,
  parameter bit SPLIT_IRQ   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padOe,
  output logic [1:0]        irqOut
);

  wrStrb_t          strb;
  rdSel_e           rdSel;
  logic [NPINS-1:0] statVec;
  logic [NPINS-1:0] maskVec;

  gpio_ctrl #(
    .ADDR_W(ADDR_W),
    .HAS_ANYEDGE(HAS_ANYEDGE)
  ) u_ctrl (
    .busSel(busSel),
    .busWr(busWr),
    .busAddr(busAddr),
    .strb(strb),
    .rdSel(rdSel)
  );

  gpio_datapath #(
    .NPINS(NPINS),
    .HAS_ANYEDGE(HAS_ANYEDGE),
    .SPLIT_IRQ(SPLIT_IRQ)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .rdSel(rdSel),
    .wdata(busWdata),
    .padIn(padIn),
    .rdata(busRdata),
    .padOut(padOut),
    .padOe(padOe),
    .irqOut(irqOut),
    .statVec(statVec),
    .maskVec(maskVec)
  );

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [NPINS-1:0] busWdata,
  input logic [NPINS-1:0] padOe,
  input logic [1:0]       irqOut,
  input wrStrb_t          strb,
  input logic [NPINS-1:0] statVec,
  input logic [NPINS-1:0] maskVec
);

  logic [NPINS-1:0] clrVec;
  assign clrVec = strb.evClr ? busWdata : '0;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dir |=> (padOe == $past(busWdata)));

  // R8
  output_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statVec & ~$past(statVec) & $past(padOe)) == '0));

  // R9
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statVec) & ~$past(clrVec) & ~statVec) == '0));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> (irqOut == 2'b00));

  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(statVec & maskVec) |-> $stable(irqOut));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .busWdata(busWdata),
  .padOe(padOe),
  .irqOut(irqOut),
  .strb(strb),
  .statVec(statVec),
  .maskVec(maskVec)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] padIn = '0;
  logic [31:0] rdA, rdB, outA, outB, oeA, oeB;
  logic [1:0]  irqA, irqB;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] shDir = '0, shLo = '0, shHi = '0, shAny = '0, shMask = '0;
  logic [31:0] curPad = '0, expA = '0, expB = '0;

  always #(PERIOD/2) clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdA),
    .padIn(padIn), .padOut(outA), .padOe(oeA), .irqOut(irqA));

  gpio_irq_port #(.HAS_ANYEDGE(1'b0), .SPLIT_IRQ(1'b1)) i_gpio_irq_portB (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdB),
    .padIn(padIn), .padOut(outB), .padOe(oeB), .irqOut(irqB));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    va = rdA; vb = rdB;
    busSel = 1'b0;
  endtask

  function automatic logic [31:0] hitsOf(logic [31:0] o, logic [31:0] n,
      logic [31:0] d, logic [31:0] lo, logic [31:0] hi, logic [31:0] an);
    logic [63:0] cfg;
    logic [31:0] h;
    cfg = {hi, lo};
    h = '0;
    for (int i = 0; i < 32; i++) begin
      if (!d[i]) begin
        if (an[i])            h[i] = o[i] != n[i];
        else if (cfg[2*i+1])  h[i] = (o[i] != n[i]) && (n[i] != cfg[2*i]);
        else                  h[i] = n[i] == cfg[2*i];
      end
    end
    return h;
  endfunction

  function automatic logic [31:0] pat(int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_0000;
      3: return 32'hA5A5_C33C;
      4: return 32'h5A5A_3CC3;
      5: return 32'h0000_FFFF;
      6: return 32'hFFFF_0000;
      default: return 32'h0F0F_0F0F;
    endcase
  endfunction

  task automatic checkEvents(string req);
    logic [31:0] a, b;
    rd(5'h18, a, b);
    check({req, " event A"}, a, expA);
    check({req, " event B"}, b, expB);
  endtask

  task automatic padStep(logic [31:0] nv, string req);
    @(negedge clk);
    padIn = nv;
    repeat (4) @(posedge clk);
    expA |= hitsOf(curPad, nv, shDir, shLo, shHi, shAny);
    expB |= hitsOf(curPad, nv, shDir, shLo, shHi, 32'h0);
    curPad = nv;
    checkEvents(req);
  endtask

  task automatic configure(logic [31:0] d, logic [31:0] lo, logic [31:0] hi, logic [31:0] an);
    wr(5'h04, d);  shDir = d;
    wr(5'h0C, lo); shLo = lo;
    wr(5'h10, hi); shHi = hi;
    wr(5'h1C, an); shAny = an;
    repeat (2) @(posedge clk);
    wr(5'h18, 32'hFFFF_FFFF);
    expA = hitsOf(curPad, curPad, shDir, shLo, shHi, shAny);
    expB = hitsOf(curPad, curPad, shDir, shLo, shHi, 32'h0);
  endtask

  function automatic logic [31:0] mixedCfg(int k, int base);
    logic [31:0] w;
    for (int j = 0; j < 16; j++) w[2*j +: 2] = 2'((base + j + k) % 4);
    return w;
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    // R1: reset values, read while reset is held
    repeat (3) @(posedge clk);
    for (int w = 0; w < 8; w++) begin
      rd(5'(w * 4), a, b);
      check("R1 reset word A", a, 32'h0);
      check("R1 reset word B", b, 32'h0);
    end
    check("R1 reset oe", oeA | outA, 32'h0);
    check("R1 reset irq", {30'h0, irqA | irqB}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 / R3: outputs, direction and merged reads
    wr(5'h00, 32'h1234_ABCD);
    wr(5'h04, 32'hFF00_FF00);
    check("R2 padOut", outA, 32'h1234_ABCD);
    check("R2 padOe", oeB, 32'hFF00_FF00);
    rd(5'h04, a, b);
    check("R2 dir readback", a, 32'hFF00_FF00);
    @(negedge clk);
    padIn = 32'hF0F0_F0F0;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b1; busAddr = 5'h08; #1;
    check("R3 pad one edge", rdA, 32'h0);
    busSel = 1'b0;
    @(posedge clk);
    rd(5'h08, a, b);
    check("R3 pad two edges", a, 32'hF0F0_F0F0 & 32'h00FF_00FF);
    rd(5'h00, a, b);
    check("R3 data merge", a, (32'h1234_ABCD & 32'hFF00_FF00) | (32'hF0F0_F0F0 & 32'h00FF_00FF));
    curPad = 32'hF0F0_F0F0;

    // R4 R5 R6: uniform mode sweep on all pins, all inputs
    for (int m = 0; m < 4; m++) begin
      logic [31:0] w;
      for (int j = 0; j < 16; j++) w[2*j +: 2] = 2'(m);
      configure(32'h0, w, w, 32'h0);
      checkEvents(m < 2 ? "R5 level settle" : "R6 edge settle");
      for (int k = 0; k < 8; k++) padStep(pat(k), m < 2 ? "R5 level" : "R6 edge");
    end

    // R4: per-pin mixed modes, distinct between halves
    for (int k = 0; k < 4; k++) begin
      configure(32'h0, mixedCfg(k, 0), mixedCfg(k, 1), 32'h0);
      checkEvents("R4 mixed settle");
      for (int s = 0; s < 8; s++) padStep(pat(s) ^ 32'h0000_00FF, "R4 mixed");
    end

    // R7 and R11: any-edge override on A, absent on B
    configure(32'h0, 32'h5555_5555, 32'h0000_0000, 32'h00FF_F00F);
    rd(5'h1C, a, b);
    check("R7 any readback", a, 32'h00FF_F00F);
    check("R11 any absent reads zero", b, 32'h0);
    for (int s = 0; s < 8; s++) padStep(pat(s), "R7 any-edge");

    // R8: output pins never raise events
    configure(32'hFFFF_0000, 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF);
    checkEvents("R8 outputs settle");
    for (int s = 0; s < 8; s++) padStep(pat(s), "R8 outputs");

    // R9: write-one-to-clear and same-cycle detection wins
    configure(32'h0, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0);
    padStep(32'h0, "R9 base");
    padStep(32'h0000_000F, "R9 set");
    wr(5'h18, 32'h0000_0005);
    expA &= ~32'h5; expB &= ~32'h5;
    checkEvents("R9 partial clear");
    padStep(32'h0, "R9 fall");
    @(negedge clk);
    padIn = 32'h0000_0002;
    @(posedge clk);
    @(posedge clk);
    wr(5'h18, 32'h0000_0002);
    curPad = 32'h0000_0002;
    checkEvents("R9 detect beats clear");
    wr(5'h18, 32'hFFFF_FFFF);
    expA = '0; expB = '0;
    checkEvents("R9 full clear");

    // R10: interrupt combining, single and split
    configure(32'h0, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0);
    padStep(32'h0, "R10 base");
    padStep(32'h0002_0000, "R10 upper event");
    wr(5'h14, 32'h0000_FFFF); shMask = 32'h0000_FFFF;
    @(negedge clk);
    check("R10 masked off A", {30'h0, irqA}, 32'h0);
    check("R10 masked off B", {30'h0, irqB}, 32'h0);
    wr(5'h14, 32'hFFFF_0000);
    @(negedge clk);
    check("R10 single irq", {30'h0, irqA}, 32'h1);
    check("R10 split upper", {30'h0, irqB}, 32'h2);
    padStep(32'h0002_0008, "R10 lower event");
    wr(5'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 split both", {30'h0, irqB}, 32'h3);
    wr(5'h18, 32'h0002_0000);
    @(negedge clk);
    check("R10 split lower only", {30'h0, irqB}, 32'h1);
    check("R10 single still", {30'h0, irqA}, 32'h1);

    // R11: misaligned and read-only offsets
    wr(5'h06, 32'hDEAD_BEEF);
    rd(5'h04, a, b);
    check("R11 misaligned write ignored", a, 32'h0);
    rd(5'h05, a, b);
    check("R11 misaligned read zero", a, 32'h0);
    wr(5'h08, 32'hFFFF_FFFF);
    check("R11 pad write no effect", oeA | outA, 32'h1234_ABCD);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, a, b);
    check("R11 absent any write ignored", b, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule